// File: doc/BRIEF.md
# Highway and Farmroad Crossing Lamp Controller

The block sequences the lamps at a junction where a busy highway meets a farmroad that sees little traffic. The highway holds green by default. A single vehicle-detect input reports a car waiting on the farmroad. The block sets one green, yellow or red lamp for each road. Every phase change is gated by a built-in interval timer. That timer measures a short interval, which times the yellow phases, and a long interval, which times the green phases.

The highway gives up green only when a car is waiting and the long interval has run out since the last phase change. The farmroad keeps green until the car is gone or the long interval runs out, whichever comes first. Each yellow lasts for the short interval. The timer-restart strobe is brought out as a port, so the phase edges can be seen. With SHORT_CYC = S and LONG_CYC = L, a timer-gated phase lasts S+1 or L+1 cycles: the exit is decided in the cycle in which the count reaches its limit.

Top module: `tfc_crossing_ctrl`

## Requirements
- R1: While rst_ni is low, the highway lamp shows green and the farmroad lamp shows red. The timer is cleared, so the first exit from highway green comes no earlier than LONG_CYC+1 cycles after reset is released.
- R2: While car_i is low, highway green is held for any length of time.
- R3: Highway green moves to highway yellow at the first clock edge at which car_i is high and at least LONG_CYC cycles have passed since the last timer restart.
- R4: Highway yellow lasts exactly SHORT_CYC+1 cycles and then moves to farmroad green.
- R5: Farmroad green moves to farmroad yellow at the first edge at which car_i is low.
- R6: Farmroad green moves to farmroad yellow after LONG_CYC+1 cycles even if car_i stays high.
- R7: Farmroad yellow lasts exactly SHORT_CYC+1 cycles and then returns to highway green.
- R8: tmr_start_o is high for exactly the one cycle before each phase change and is low in every other cycle.
- R9: Each lamp output is one-hot: bit 0 is green, bit 1 is yellow and bit 2 is red. In every cycle at least one road shows red.
- R10: On each return to highway green the timer restarts. A car that is already waiting therefore still sees LONG_CYC+1 cycles of highway green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_i | input | 1 | A vehicle is waiting on the farmroad |
| hwy_lamp_o | output | 3 | Highway lamp, one-hot {red, yellow, green} |
| farm_lamp_o | output | 3 | Farmroad lamp, one-hot {red, yellow, green} |
| tmr_start_o | output | 1 | Timer restart strobe, high in the last cycle of a phase |

## Verification
The assertions check four things on every cycle: the lamps stay one-hot, the two roads never both show a non-red lamp, the phase changes exactly when the strobe was high, and highway green holds while the long interval is still open or no car is waiting. Only the bench scenarios can show the exact phase lengths. These are the yellow durations, the farmroad green cut short by timeout versus by the car leaving, and the restart of the minimum highway green after each cycle. The bench checks these against a cycle model driven by both steady and pseudo-random car patterns.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_e;

  localparam int LAMP_W   = 3;
  localparam int LAMP_GRN = 0;
  localparam int LAMP_YEL = 1;
  localparam int LAMP_RED = 2;

  localparam logic [LAMP_W-1:0] LAMP_G = 3'b001;
  localparam logic [LAMP_W-1:0] LAMP_Y = 3'b010;
  localparam logic [LAMP_W-1:0] LAMP_R = 3'b100;
endpackage

// File: rtl/tfc_interval_timer.sv
module tfc_interval_timer #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic short_done_o,
  output logic long_done_o
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

  logic [CNT_W-1:0] cnt_q;

  // saturates at the long limit so the flags hold until the next restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= '0;
    else if (cnt_q != LONG_LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign short_done_o = (cnt_q >= SHORT_LIM);
  assign long_done_o  = (cnt_q >= LONG_LIM);

  assert_long_implies_short_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_done_o |-> short_done_o);
  assert_restart_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !long_done_o);
endmodule

// File: rtl/tfc_phase_fsm.sv
module tfc_phase_fsm
  import tfc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   car_i,
  input  logic   short_done_i,
  input  logic   long_done_i,
  output phase_e phase_o,
  output logic   start_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_HWY_GO:    if (car_i && long_done_i)  phase_d = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done_i)          phase_d = PH_FARM_GO;
      PH_FARM_GO:   if (!car_i || long_done_i) phase_d = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done_i)          phase_d = PH_HWY_GO;
      default:                                 phase_d = PH_HWY_GO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_HWY_GO;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign start_o = (phase_d != phase_q);

  assert_strobe_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> phase_q != $past(phase_q));
  assert_no_strobe_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> $stable(phase_q));
  assert_hold_no_car_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HWY_GO && !car_i) |=> phase_q == PH_HWY_GO);
  assert_min_green_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HWY_GO && !long_done_i) |=> phase_q == PH_HWY_GO);
endmodule

// File: rtl/tfc_lamp_decode.sv
module tfc_lamp_decode
  import tfc_pkg::*;
(
  input  phase_e             phase_i,
  output logic [LAMP_W-1:0]  hwy_o,
  output logic [LAMP_W-1:0]  farm_o
);
  always_comb begin
    unique case (phase_i)
      PH_HWY_GO:    begin hwy_o = LAMP_G; farm_o = LAMP_R; end
      PH_HWY_WARN:  begin hwy_o = LAMP_Y; farm_o = LAMP_R; end
      PH_FARM_GO:   begin hwy_o = LAMP_R; farm_o = LAMP_G; end
      PH_FARM_WARN: begin hwy_o = LAMP_R; farm_o = LAMP_Y; end
      default:      begin hwy_o = LAMP_R; farm_o = LAMP_R; end
    endcase
  end

  always_comb begin
    assert_hwy_onehot_R9:  assert ($onehot(hwy_o));
    assert_farm_onehot_R9: assert ($onehot(farm_o));
  end
endmodule

// File: rtl/tfc_crossing_ctrl.sv
module tfc_crossing_ctrl
  import tfc_pkg::*;
#(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              car_i,
  output logic [LAMP_W-1:0] hwy_lamp_o,
  output logic [LAMP_W-1:0] farm_lamp_o,
  output logic              tmr_start_o
);
  logic   short_done, long_done, start;
  phase_e phase;

  tfc_interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .short_done_o(short_done), .long_done_o(long_done)
  );

  tfc_phase_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .car_i(car_i),
    .short_done_i(short_done), .long_done_i(long_done),
    .phase_o(phase), .start_o(start)
  );

  tfc_lamp_decode u_dec (
    .phase_i(phase), .hwy_o(hwy_lamp_o), .farm_o(farm_lamp_o)
  );

  assign tmr_start_o = start;

  assert_one_road_red_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwy_lamp_o[LAMP_RED] || farm_lamp_o[LAMP_RED]);
  assert_reset_green_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (hwy_lamp_o == LAMP_G && farm_lamp_o == LAMP_R));
endmodule

// File: tb/tfc_crossing_ctrl_test.sv
`timescale 1ns/1ps
module tfc_crossing_ctrl_test;
  localparam int S = 3;
  localparam int L = 8;

  logic clk = 0, rst_ni = 0, car = 0;
  logic [2:0] hwy, farm;
  logic strobe;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  tfc_crossing_ctrl #(.SHORT_CYC(S), .LONG_CYC(L)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .car_i(car),
    .hwy_lamp_o(hwy), .farm_lamp_o(farm), .tmr_start_o(strobe)
  );

  // scoreboard queues
  logic [2:0] q_h[$], q_f[$];
  logic       q_s[$];
  string      q_tag[$];

  // spec model: phase 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
  int m_ph = 0, m_cnt = 0;
  bit m_returned = 0;

  function automatic logic [2:0] lamp_h(int p);
    return (p == 0) ? 3'b001 : (p == 1) ? 3'b010 : 3'b100;
  endfunction
  function automatic logic [2:0] lamp_f(int p);
    return (p == 2) ? 3'b001 : (p == 3) ? 3'b010 : 3'b100;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // driver: sets car for this cycle, predicts outputs, advances model
  task automatic step(bit c);
    bit    mv;
    string tag;
    car = c;
    case (m_ph)
      0: mv = c && (m_cnt >= L);
      1: mv = (m_cnt >= S);
      2: mv = !c || (m_cnt >= L);
      default: mv = (m_cnt >= S);
    endcase
    case (m_ph)
      0: tag = m_returned ? "R10" : (c ? "R3" : "R2");
      1: tag = "R4";
      2: tag = c ? "R6" : "R5";
      default: tag = "R7";
    endcase
    q_h.push_back(lamp_h(m_ph));
    q_f.push_back(lamp_f(m_ph));
    q_s.push_back(mv);
    q_tag.push_back(tag);
    if (mv) begin
      m_cnt = 0;
      if (m_ph == 3) m_returned = 1;
      else if (m_ph == 0) m_returned = 0;
      m_ph = (m_ph + 1) % 4;
    end else if (m_cnt < L) m_cnt++;
    @(negedge clk);
  endtask

  // monitor
  always begin
    @(negedge clk);
    #1;
    cyc++;
    if (q_h.size() > 0) begin
      string t;
      logic [2:0] eh, ef;
      logic es;
      t = q_tag.pop_front(); eh = q_h.pop_front(); ef = q_f.pop_front(); es = q_s.pop_front();
      check({t, " hwy"}, hwy, eh);
      check({t, " farm"}, farm, ef);
      check("R8 strobe", {2'b0, strobe}, {2'b0, es});
      check("R9 hwy onehot", {2'b0, $onehot(hwy)}, 3'b001);
      check("R9 farm onehot", {2'b0, $onehot(farm)}, 3'b001);
      check("R9 one red", {2'b0, hwy[2] | farm[2]}, 3'b001);
    end
  end

  initial begin
    if (cyc > 20000) ;
    fork
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    car = 1;
    #1;
    check("R1 reset hwy", hwy, 3'b001);   // car high during reset has no effect
    check("R1 reset farm", farm, 3'b100);
    check("R1 reset strobe", {2'b0, strobe}, 3'b000);
    @(negedge clk);
    rst_ni = 1;
    // R1: car waiting right after reset still waits for the long interval
    repeat (14) step(1);
    // R2: highway green held without a car
    repeat (25) step(0);
    // R6 timeout with car held, then R10 minimum green with car waiting
    repeat (40) step(1);
    // R5: car leaves during farm green
    repeat (4) step(1);
    while (m_ph != 2) step(1);
    step(1);
    step(0);
    repeat (10) step(0);
    // pseudo-random arrivals
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[1]);
    end
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule